// File: doc/BRIEF.md
# Supply Supervisor with Bus-Activity Watchdog

This block generates the system reset for a microcontroller subsystem. It works from four digital inputs. The synchronous reset input stands for the power-on event. A flag from an external supply comparator reports a low supply. A serial data line is watched for activity. A two-bit watchdog interval setting is latched while the reset input is low. From these it drives one reset output, and a parameter sets whether that output is active-low or active-high.

After power-on the output is held for a fixed hold time so that the supply and oscillator can settle. While the supply flag is high the output is held. Once the flag clears, the output stays held for a further recovery time. The watchdog is restarted by any rising or falling edge on the watched line. If the line keeps one level, high or low, for the selected interval, the watchdog issues a reset pulse as long as the power-on hold. All periods are counted in ticks of a prescaler, so a short tick can be used to test the block.

Top module: `supv_reset_top`

## Requirements
- R1: While `rst_n` is low the output is at its asserted level. After `rst_n` rises, with the supply good, the output deasserts on clock edge POR_TICKS*TICK_DIV+1, counting the first edge with `rst_n` high as edge 1.
- R2: `supply_low` passes through a two-stage synchronizer. The output reaches its asserted level on the third clock edge after `supply_low` rises.
- R3: After `supply_low` falls, the output stays asserted and deasserts on clock edge RECOVER_TICKS*TICK_DIV+3 after the fall.
- R4: The interval code held in `wd_sel_init` when reset is taken selects the watchdog limit: 2'b00 selects WD_SHORT_TICKS, 2'b01 selects WD_MID_TICKS and 2'b10 selects WD_LONG_TICKS. With no edge on `wd_line`, the output stays deasserted for exactly limit*TICK_DIV cycles and then asserts. This holds whether the line is held high or held low.
- R5: Any change of `wd_line`, rising or falling, restarts the watchdog. With no further change, reset asserts on clock edge limit*TICK_DIV+4 after the change.
- R6: A watchdog reset holds the output asserted for POR_TICKS*TICK_DIV cycles. The watchdog then counts again from zero, so the next quiet interval is again limit*TICK_DIV cycles.
- R7: Code 2'b11 disables the watchdog, and no reset is produced however long the line stays quiet.
- R8: Changes on `wd_sel_init` while `rst_n` is high have no effect on the watchdog interval.
- R9: A low supply takes priority and the watchdog does not count while reset is asserted. A low supply held for longer than the watchdog interval ends after the recovery time alone, and the following quiet interval is a full limit*TICK_DIV cycles.
- R10: With ACTIVE_LOW=1 the output is 0 when asserted. With ACTIVE_LOW=0 it is 1 when asserted. Timing is the same for both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; models the power-on event and loads the interval setting |
| supply_low | input | 1 | Asynchronous low-supply flag from the external comparator, high when the supply is below the trip point |
| wd_line | input | 1 | Asynchronous serial data line watched for activity |
| wd_sel_init | input | 2 | Watchdog interval code captured during reset: 00 short, 01 mid, 10 long, 11 off |
| sys_rst | output | 1 | System reset, at the polarity set by ACTIVE_LOW |

## Verification
The hardest state to reach is a watchdog counter that is one tick from expiry when a line edge arrives. The edge passes through three flops before it clears the counter, and a wrong restart shows up only as an interval a few cycles too long or too short. The bench drives the line in a train of toggles, each placed just short of the timeout. It alternates rising and falling edges, then measures the exact cycle at which reset asserts after the last toggle. It also holds the supply low for far longer than the watchdog interval, which shows whether the watchdog kept counting behind the supply hold.

// File: rtl/supv_pkg.sv
// Package: shared types for the supply supervisor.
// Assumes: two-bit interval codes, with the top code meaning "watchdog off".
package supv_pkg;

    typedef enum logic [1:0] {
        WD_SEL_SHORT = 2'b00,
        WD_SEL_MID   = 2'b01,
        WD_SEL_LONG  = 2'b10,
        WD_SEL_OFF   = 2'b11
    } wd_sel_e;

endpackage

// File: rtl/supv_sync.sv
// Module: supv_sync
// Carries an asynchronous vector into the clock domain through a chain of
// STAGES flops. Assumes STAGES >= 2. Every stage resets to zero.
module supv_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/supv_tick_gen.sv
// Module: supv_tick_gen
// Prescaler. It emits a one-cycle tick every DIV cycles. A restart pulse
// realigns the phase, so the next tick comes DIV cycles after the restart.
// Assumes DIV >= 1.
module supv_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    // Count the cycles of one tick period and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/supv_wdt.sv
// Module: supv_wdt
// Bus-activity watchdog. It detects edges on the synchronized line and
// counts prescaler ticks of quiet time against the selected limit. It
// raises a one-cycle expire pulse when the limit is reached. The count is
// held at zero while frozen, while the watchdog is off, or when an edge is
// seen. Assumes all limits are >= 1.
module supv_wdt
    import supv_pkg::*;
#(
    parameter int DIV     = 4,
    parameter int T_SHORT = 6,
    parameter int T_MID   = 10,
    parameter int T_LONG  = 15
) (
    input  logic    clk,
    input  logic    rst_n,
    input  wd_sel_e sel,
    input  logic    line_s,
    input  logic    freeze,
    output logic    expire
);

    localparam int TMAX_A = (T_SHORT > T_MID) ? T_SHORT : T_MID;
    localparam int TMAX   = (TMAX_A > T_LONG) ? TMAX_A : T_LONG;
    localparam int CW     = $clog2(TMAX + 1);

    // Map an interval code to its tick limit.
    function automatic logic [CW-1:0] limit_of(input wd_sel_e s);
        case (s)
            WD_SEL_SHORT: limit_of = CW'(T_SHORT);
            WD_SEL_MID:   limit_of = CW'(T_MID);
            WD_SEL_LONG:  limit_of = CW'(T_LONG);
            default:      limit_of = CW'(TMAX);
        endcase
    endfunction

    logic          line_d;
    logic          edge_seen;
    logic          enabled;
    logic          clear;
    logic          tick;
    logic          at_last;
    logic [CW-1:0] lim_m1;
    logic [CW-1:0] cnt_q;

    // Keep the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_d <= 1'b0;
        end else begin
            line_d <= line_s;
        end
    end

    assign edge_seen = line_s ^ line_d;
    assign enabled   = (sel != WD_SEL_OFF);
    assign clear     = !enabled || freeze || edge_seen;
    assign lim_m1    = limit_of(sel) - CW'(1);
    assign at_last   = (cnt_q == lim_m1);
    assign expire    = tick && at_last && !clear;

    supv_tick_gen #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (clear),
        .tick    (tick)
    );

    // Count quiet ticks and wrap to zero on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_last ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/supv_hold_seq.sv
// Module: supv_hold_seq
// Reset hold sequencer. It keeps reset active while the synchronized
// low-supply flag is high, then for REC_T ticks after the flag clears.
// After power-on, and after a watchdog expiry, it keeps reset active for
// POR_T ticks. Every load realigns the prescaler, so hold times are exact.
// Assumes POR_T >= 1.
module supv_hold_seq #(
    parameter int DIV   = 4,
    parameter int POR_T = 5,
    parameter int REC_T = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_s,
    input  logic wd_expire,
    output logic active
);

    localparam int HMAX = (POR_T > REC_T) ? POR_T : REC_T;
    localparam int HW   = $clog2(HMAX + 1);

    logic          tick;
    logic          load_por;
    logic          restart;
    logic [HW-1:0] hold_q;

    assign load_por = wd_expire && !active;
    assign restart  = low_s || load_por;
    assign active   = low_s || (hold_q != '0);

    supv_tick_gen #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    // Load or count down the remaining hold ticks; a low supply wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= HW'(POR_T);
        end else if (low_s) begin
            hold_q <= HW'(REC_T);
        end else if (load_por) begin
            hold_q <= HW'(POR_T);
        end else if (tick && hold_q != '0) begin
            hold_q <= hold_q - HW'(1);
        end
    end

endmodule

// File: rtl/supv_reset_top.sv
// Module: supv_reset_top
// Supply supervisor top. It synchronizes the low-supply flag and the
// watched data line. It latches the watchdog interval code while rst_n is
// low and keeps it until the next reset. It combines the hold sequencer and
// the watchdog into one registered reset at the polarity set by ACTIVE_LOW.
// Assumes rst_n models the power-on event and stays low for a few cycles.
module supv_reset_top
    import supv_pkg::*;
#(
    parameter int TICK_DIV       = 1000,
    parameter int POR_TICKS      = 250,
    parameter int RECOVER_TICKS  = 250,
    parameter int WD_SHORT_TICKS = 150,
    parameter int WD_MID_TICKS   = 600,
    parameter int WD_LONG_TICKS  = 1400,
    parameter int SYNC_STAGES    = 2,
    parameter bit ACTIVE_LOW     = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_low,
    input  logic       wd_line,
    input  logic [1:0] wd_sel_init,
    output logic       sys_rst
);

    wd_sel_e cfg_q;
    logic    low_s;
    logic    line_s;
    logic    hold_active;
    logic    wd_expire;
    logic    rst_q;

    // Latch the interval code during reset and keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= wd_sel_e'(wd_sel_init);
        end
    end

    supv_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_low (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (supply_low),
        .q     (low_s)
    );

    supv_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_line (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wd_line),
        .q     (line_s)
    );

    supv_hold_seq #(
        .DIV   (TICK_DIV),
        .POR_T (POR_TICKS),
        .REC_T (RECOVER_TICKS)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_s     (low_s),
        .wd_expire (wd_expire),
        .active    (hold_active)
    );

    supv_wdt #(
        .DIV     (TICK_DIV),
        .T_SHORT (WD_SHORT_TICKS),
        .T_MID   (WD_MID_TICKS),
        .T_LONG  (WD_LONG_TICKS)
    ) u_wdt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (cfg_q),
        .line_s (line_s),
        .freeze (hold_active),
        .expire (wd_expire)
    );

    // Register the combined reset so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= hold_active;
        end
    end

    generate
        if (ACTIVE_LOW) begin : g_out_low
            assign sys_rst = ~rst_q;
        end else begin : g_out_high
            assign sys_rst = rst_q;
        end
    endgenerate

endmodule

// File: rtl/supv_reset_chk.sv
// Module: supv_reset_chk
// Assertion checker bound into supv_reset_top. It watches the port-level
// reset against the synchronized supply flag, the watchdog expiry and the
// latched interval code. A small counter of cycles since reset keeps every
// $past look-back inside the time since reset.
module supv_reset_chk #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_low,
    input logic       sys_rst,
    input logic       low_s,
    input logic       wd_expire,
    input logic [1:0] cfg
);

    logic       asserted;
    logic [1:0] since_q;

    assign asserted = ACTIVE_LOW ? !sys_rst : sys_rst;

    // Count cycles since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= 2'd0;
        end else if (since_q != 2'd3) begin
            since_q <= since_q + 2'd1;
        end
    end

    assert_reset_level_R1: assert property (@(posedge clk)
        !rst_n |=> asserted);

    assert_low_supply_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd3 && supply_low && $past(supply_low) && $past(supply_low, 2))
        |=> asserted);

    assert_release_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd3 && $fell(asserted)) |-> !$past(low_s));

    assert_off_never_expires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'b11) |-> !wd_expire);

    assert_rise_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd3 && $rose(asserted)) |-> ($past(low_s) || $past(wd_expire, 2)));

endmodule

bind supv_reset_top supv_reset_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_low (supply_low),
    .sys_rst    (sys_rst),
    .low_s      (low_s),
    .wd_expire  (wd_expire),
    .cfg        (cfg_q)
);

// File: tb/supv_reset_top_bench.sv
// Bench for supv_reset_top. It builds two instances that differ only in
// output polarity, sweeps every interval code and measures each reset
// edge to the exact cycle against arithmetic expectations.
module supv_reset_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int POR        = 5;
    localparam int REC        = 3;
    localparam int T0         = 6;
    localparam int T1         = 10;
    localparam int T2         = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_low = 1'b0;
    logic       wd_line = 1'b0;
    logic [1:0] wd_sel_init = 2'b00;
    logic       sys_rst_lo;
    logic       sys_rst_hi;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  pol_bad = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    supv_reset_top #(
        .TICK_DIV(DIV), .POR_TICKS(POR), .RECOVER_TICKS(REC),
        .WD_SHORT_TICKS(T0), .WD_MID_TICKS(T1), .WD_LONG_TICKS(T2),
        .SYNC_STAGES(2), .ACTIVE_LOW(1'b1)
    ) u_supv_reset_top (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
        .wd_line(wd_line), .wd_sel_init(wd_sel_init), .sys_rst(sys_rst_lo)
    );

    supv_reset_top #(
        .TICK_DIV(DIV), .POR_TICKS(POR), .RECOVER_TICKS(REC),
        .WD_SHORT_TICKS(T0), .WD_MID_TICKS(T1), .WD_LONG_TICKS(T2),
        .SYNC_STAGES(2), .ACTIVE_LOW(1'b0)
    ) u_supv_reset_top_hi (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
        .wd_line(wd_line), .wd_sel_init(wd_sel_init), .sys_rst(sys_rst_hi)
    );

    // R10: the two polarities must be exact complements at every sample.
    always @(negedge clk) begin
        if (sys_rst_lo !== ~sys_rst_hi) pol_bad++;
    end

    function automatic bit in_rst();
        return (sys_rst_lo == 1'b0);
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count clock edges until the reset reaches the wanted state.
    task automatic wait_level(input bit want, output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (in_rst() != want && n < 5000);
    endtask

    task automatic do_reset(input logic [1:0] sel);
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        wd_sel_init = sel;
        repeat (3) @(negedge clk);
        check_eq("R1 asserted while rst_n low", int'(in_rst()), 1);
        check_eq("R10 active-high copy during reset", int'(sys_rst_hi), 1);
        rst_n = 1'b1;
        wait_level(1'b0, n);
        check_eq("R1 power-on hold length", n, POR * DIV + 1);
    endtask

    initial begin
        int n;
        int bad;
        int lim;

        // R4, R6, R8: sweep the three enabled codes, with the line stuck at both levels.
        for (int sel = 0; sel < 3; sel++) begin
            lim = (sel == 0) ? T0 : (sel == 1) ? T1 : T2;
            wd_line = sel[0];
            do_reset(2'(sel));
            wd_sel_init = (sel == 0) ? 2'b10 : 2'b11;   // R8: ignored after reset
            wait_level(1'b1, n);
            check_eq("R4 quiet interval before watchdog reset", n, lim * DIV);
            wait_level(1'b0, n);
            check_eq("R6 watchdog pulse width", n, POR * DIV);
            wait_level(1'b1, n);
            check_eq("R6 R8 second interval restarts from zero", n, lim * DIV);
        end

        // R7: code 11 disables the watchdog.
        wd_line = 1'b0;
        do_reset(2'b11);
        wd_sel_init = 2'b00;
        bad = 0;
        repeat (T2 * DIV * 3) begin
            @(negedge clk);
            bad += int'(in_rst());
        end
        check_eq("R7 no reset while disabled", bad, 0);

        // R5: alternating edges each placed just short of the timeout.
        wd_line = 1'b1;
        do_reset(2'b01);
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            repeat (T1 * DIV - 8) begin
                @(negedge clk);
                bad += int'(in_rst());
            end
            wd_line = ~wd_line;
        end
        check_eq("R5 kicks keep reset released", bad, 0);
        wait_level(1'b1, n);
        check_eq("R5 timeout measured from last edge", n, T1 * DIV + 4);

        // R2, R3, R9: low supply is held far longer than the watchdog interval.
        wd_line = 1'b0;
        do_reset(2'b00);
        @(negedge clk);
        supply_low = 1'b1;
        wait_level(1'b1, n);
        check_eq("R2 low-supply assertion latency", n, 3);
        bad = 0;
        repeat (T0 * DIV * 3) begin
            @(negedge clk);
            bad += int'(!in_rst());
        end
        check_eq("R9 reset held through long low supply", bad, 0);
        supply_low = 1'b0;
        wait_level(1'b0, n);
        check_eq("R3 recovery hold length", n, REC * DIV + 3);
        wait_level(1'b1, n);
        check_eq("R9 watchdog frozen during low supply", n, T0 * DIV);

        check_eq("R10 polarity mismatches", pol_bad, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule